// File: doc/BRIEF.md
# Scanner Front-End Color Channel Sequencer

This block decides which of the three color inputs (red, green, blue) the shared analog multiplexer feeds to the single converter of a scanner front end. It runs on the converter sample clock. One sample is taken on every rising edge. The block drives a 2-bit channel pointer, `chan_sel`. It also labels each conversion result with the color that was sampled, once the converter's fixed pipeline latency has elapsed.

The pointer can come from three sources. The first is a free-running red, green, blue rotation, which restarts on the active-low line-start strobe. The second is a fixed color chosen by configuration bits, for single-channel scanning. The third is a pair of external select pins, which take over when the active-low override input is low. A mode latched for a line stays in force until the next line start. A reserved color code never reaches the multiplexer. It selects red and sets a sticky error flag instead.

Top module: `afe_color_seq`

## Requirements
- R1: During and directly after reset, `chan_sel` is red (00), `res_valid` is 0, `res_tag` is 00, `res_data` is 0 and `err_rsvd` is 0.
- R2: In rotation mode (the latched single-channel bit is 0, and `ext_ctl_n` is high), the edges that follow a line start sample red, green, blue, red, and so on, one color per clock. The codes are red=00, green=01 and blue=10.
- R3: A rising clock edge at which `line_start_n` is low sets the rotation pointer to red. The pointer stays red while the strobe stays low. The first sample after the strobe is released is red.
- R4: The single-channel mode bit is bit 1 of the configuration register (`cfg_single_en`). The color field is bits 3:2 (`cfg_color`), with 00 red, 01 green, 10 blue and 11 reserved. In single-channel mode every sample uses the latched color.
- R5: While `ext_ctl_n` is low, `chan_sel` follows `ext_sel` in the same cycle, with the same encoding. This overrides both the rotation and single-channel mode.
- R6: A reserved code (11) in effect, from `ext_sel` under override or from the latched color in single-channel mode, drives `chan_sel` to red. The next edge sets `err_rsvd`, which stays at 1 until reset. `chan_sel` is never 11.
- R7: The configuration inputs are captured only at edges where `line_start_n` is low. A change in the middle of a line has no effect on `chan_sel` until the next line start.
- R8: The color of the sample taken at edge k is shown on `res_tag`, with `res_valid` high, during the cycle that follows edge k+4. That is the same cycle in which `conv_data` carries that sample's result, and `res_data` then equals `conv_data`. When `res_valid` is low, `res_tag` is 00 and `res_data` is 0.
- R9: Samples taken before the first line start after reset are not valid. Samples taken at edges where `line_start_n` is low are not valid either.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Converter sample clock; one sample per rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_start_n | input | 1 | Active-low line-start strobe |
| cfg_single_en | input | 1 | Configuration bit 1: single-channel mode |
| cfg_color | input | 2 | Configuration bits 3:2: single-channel color |
| ext_ctl_n | input | 1 | Active-low external select override |
| ext_sel | input | 2 | External color select, {pin 2, pin 1} |
| conv_data | input | 12 | Converter output word |
| chan_sel | output | 2 | Multiplexer channel pointer |
| res_data | output | 12 | Result word, zero when not valid |
| res_tag | output | 2 | Color of the current result |
| res_valid | output | 1 | Result belongs to a valid sample |
| err_rsvd | output | 1 | Sticky flag: reserved color code was used |

## Verification
The assertions assume that the line-start strobe, the configuration and the override pins change only between clock edges. They also assume that `conv_data` carries the result of edge k's sample after edge k+4, as a real converter with that latency would. The bench drives every input at the falling edge, with the converter word as a cycle-indexed pattern. It compares pointer, tag, data and error against its own model once per cycle. The stimulus moves through rotation, a configuration change in the middle of a line, two single-channel colors, each override code including the reserved one, and a reserved single-channel color after a second reset.

// File: rtl/afe_seq_pkg.sv
package afe_seq_pkg;
   typedef enum logic [1:0] {
      CH_RED   = 2'b00,
      CH_GREEN = 2'b01,
      CH_BLUE  = 2'b10,
      CH_RSVD  = 2'b11
   } chan_e;

   typedef struct packed {
      logic  valid;
      chan_e tag;
   } tag_t;

   // rotation order red -> green -> blue -> red
   function automatic chan_e rot_next(chan_e c);
      case (c)
         CH_RED:   return CH_GREEN;
         CH_GREEN: return CH_BLUE;
         default:  return CH_RED;
      endcase
   endfunction
endpackage

// File: rtl/afe_seq_rotor.sv
module afe_seq_rotor
   import afe_seq_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       line_start_n,
   input  logic       cfg_single_en,
   input  logic [1:0] cfg_color,
   output chan_e      rot_ptr,
   output logic       mode_single,
   output logic [1:0] mode_color,
   output logic       line_seen
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rot_ptr     <= CH_RED;
         mode_single <= 1'b0;
         mode_color  <= 2'b00;
         line_seen   <= 1'b0;
      end else if (!line_start_n) begin
         rot_ptr     <= CH_RED;
         mode_single <= cfg_single_en;
         mode_color  <= cfg_color;
         line_seen   <= 1'b1;
      end else begin
         rot_ptr     <= rot_next(rot_ptr);
      end
   end
endmodule

// File: rtl/afe_seq_select.sv
module afe_seq_select
   import afe_seq_pkg::*;
(
   input  chan_e      rot_ptr,
   input  logic       mode_single,
   input  logic [1:0] mode_color,
   input  logic       ext_ctl_n,
   input  logic [1:0] ext_sel,
   output chan_e      chan_sel,
   output logic       rsvd_hit
);
   logic [1:0] req;

   always_comb begin
      if (!ext_ctl_n)       req = ext_sel;
      else if (mode_single) req = mode_color;
      else                  req = rot_ptr;
      rsvd_hit = (req == CH_RSVD);
      chan_sel = rsvd_hit ? CH_RED : chan_e'(req);
   end
endmodule

// File: rtl/afe_seq_tagpipe.sv
module afe_seq_tagpipe
   import afe_seq_pkg::*;
#(
   parameter int DEPTH = 5
) (
   input  logic clk,
   input  logic rst_n,
   input  tag_t in_tag,
   output tag_t out_tag
);
   tag_t stage_q [DEPTH];

   for (genvar i = 0; i < DEPTH; i++) begin : g_stage
      tag_t nxt;
      if (i == 0) begin : g_head
         assign nxt = in_tag;
      end else begin : g_body
         assign nxt = stage_q[i-1];
      end
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) stage_q[i] <= '{valid: 1'b0, tag: CH_RED};
         else        stage_q[i] <= nxt;
      end
   end

   assign out_tag = stage_q[DEPTH-1];
endmodule

// File: rtl/afe_color_seq.sv
module afe_color_seq
   import afe_seq_pkg::*;
#(
   parameter int LATENCY = 4,
   parameter int DATA_W  = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              line_start_n,
   input  logic              cfg_single_en,
   input  logic [1:0]        cfg_color,
   input  logic              ext_ctl_n,
   input  logic [1:0]        ext_sel,
   input  logic [DATA_W-1:0] conv_data,
   output logic [1:0]        chan_sel,
   output logic [DATA_W-1:0] res_data,
   output logic [1:0]        res_tag,
   output logic              res_valid,
   output logic              err_rsvd
);
   localparam int PIPE_DEPTH = LATENCY + 1;

   if (LATENCY < 1) begin : g_bad_lat
      $error("afe_color_seq: LATENCY must be at least 1");
   end
   if (DATA_W < 1) begin : g_bad_w
      $error("afe_color_seq: DATA_W must be at least 1");
   end

   chan_e      rot_ptr;
   logic       mode_single;
   logic [1:0] mode_color;
   logic       line_seen;
   chan_e      sel;
   logic       rsvd_hit;
   tag_t       smp_tag;
   tag_t       out_tag;

   afe_seq_rotor u_rotor (
      .clk           (clk),
      .rst_n         (rst_n),
      .line_start_n  (line_start_n),
      .cfg_single_en (cfg_single_en),
      .cfg_color     (cfg_color),
      .rot_ptr       (rot_ptr),
      .mode_single   (mode_single),
      .mode_color    (mode_color),
      .line_seen     (line_seen)
   );

   afe_seq_select u_select (
      .rot_ptr     (rot_ptr),
      .mode_single (mode_single),
      .mode_color  (mode_color),
      .ext_ctl_n   (ext_ctl_n),
      .ext_sel     (ext_sel),
      .chan_sel    (sel),
      .rsvd_hit    (rsvd_hit)
   );

   always_comb begin
      smp_tag.valid = line_seen && line_start_n;
      smp_tag.tag   = smp_tag.valid ? sel : CH_RED;
   end

   afe_seq_tagpipe #(.DEPTH(PIPE_DEPTH)) u_pipe (
      .clk     (clk),
      .rst_n   (rst_n),
      .in_tag  (smp_tag),
      .out_tag (out_tag)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) err_rsvd <= 1'b0;
      else        err_rsvd <= err_rsvd | rsvd_hit;
   end

   assign chan_sel  = sel;
   assign res_valid = out_tag.valid;
   assign res_tag   = out_tag.tag;
   assign res_data  = out_tag.valid ? conv_data : '0;
endmodule

// File: rtl/afe_color_seq_chk.sv
module afe_color_seq_chk
   import afe_seq_pkg::*;
(
   input logic       clk,
   input logic       rst_n,
   input logic       line_start_n,
   input logic       ext_ctl_n,
   input logic [1:0] ext_sel,
   input logic [1:0] chan_sel,
   input logic       res_valid,
   input logic       err_rsvd,
   input logic [1:0] rot_ptr,
   input logic       mode_single,
   input logic [1:0] mode_color,
   input logic       line_seen
);
   assert_start_red_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !line_start_n |=> rot_ptr == CH_RED);

   assert_rot_rg_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (line_start_n && rot_ptr == CH_RED) |=> rot_ptr == CH_GREEN);
   assert_rot_gb_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (line_start_n && rot_ptr == CH_GREEN) |=> rot_ptr == CH_BLUE);
   assert_rot_br_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (line_start_n && rot_ptr == CH_BLUE) |=> rot_ptr == CH_RED);

   assert_ext_follow_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!ext_ctl_n && ext_sel != 2'b11) |-> chan_sel == ext_sel);

   assert_rsvd_red_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (!ext_ctl_n && ext_sel == 2'b11) |-> chan_sel == CH_RED);
   assert_err_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
      err_rsvd |=> err_rsvd);
   assert_never_rsvd_R6: assert property (@(posedge clk) disable iff (!rst_n)
      chan_sel != 2'b11);

   assert_mode_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      line_start_n |=> ($stable(mode_single) && $stable(mode_color)));

   assert_no_early_valid_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !line_seen |-> !res_valid);
endmodule

bind afe_color_seq afe_color_seq_chk chk_i (
   .clk          (clk),
   .rst_n        (rst_n),
   .line_start_n (line_start_n),
   .ext_ctl_n    (ext_ctl_n),
   .ext_sel      (ext_sel),
   .chan_sel     (chan_sel),
   .res_valid    (res_valid),
   .err_rsvd     (err_rsvd),
   .rot_ptr      (rot_ptr),
   .mode_single  (mode_single),
   .mode_color   (mode_color),
   .line_seen    (line_seen)
);

// File: tb/afe_color_seq_tb.sv
module afe_color_seq_tb_top;
   localparam int LAT = 4;
   localparam int DW  = 12;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          line_start_n = 1'b1;
   logic          cfg_single_en = 1'b0;
   logic [1:0]    cfg_color = 2'b00;
   logic          ext_ctl_n = 1'b1;
   logic [1:0]    ext_sel = 2'b00;
   logic [DW-1:0] conv_data = '0;
   logic [1:0]    chan_sel;
   logic [DW-1:0] res_data;
   logic [1:0]    res_tag;
   logic          res_valid;
   logic          err_rsvd;

   int n_chk = 0;
   int n_fail = 0;
   int cyc = 0;

   always #2.5 clk = ~clk;

   afe_color_seq #(.LATENCY(LAT), .DATA_W(DW)) dut_i (
      .clk(clk), .rst_n(rst_n), .line_start_n(line_start_n),
      .cfg_single_en(cfg_single_en), .cfg_color(cfg_color),
      .ext_ctl_n(ext_ctl_n), .ext_sel(ext_sel), .conv_data(conv_data),
      .chan_sel(chan_sel), .res_data(res_data), .res_tag(res_tag),
      .res_valid(res_valid), .err_rsvd(err_rsvd)
   );

   // behavioural reference
   int m_rot = 0;
   int m_single = 0;
   int m_color = 0;
   int m_seen = 0;
   int m_err = 0;
   int m_pv [LAT+1];
   int m_pt [LAT+1];

   function automatic int m_req();
      if (!ext_ctl_n)    return int'(ext_sel);
      if (m_single != 0) return m_color;
      return m_rot;
   endfunction

   function automatic int m_eff();
      return (m_req() == 3) ? 0 : m_req();
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_rot = 0; m_single = 0; m_color = 0; m_seen = 0; m_err = 0;
         for (int i = 0; i <= LAT; i++) begin m_pv[i] = 0; m_pt[i] = 0; end
      end else begin
         int sv, st;
         sv = (line_start_n && m_seen != 0) ? 1 : 0;
         st = sv ? m_eff() : 0;
         for (int i = LAT; i > 0; i--) begin m_pv[i] = m_pv[i-1]; m_pt[i] = m_pt[i-1]; end
         m_pv[0] = sv; m_pt[0] = st;
         if (m_req() == 3) m_err = 1;
         if (!line_start_n) begin
            m_rot = 0; m_single = int'(cfg_single_en); m_color = int'(cfg_color); m_seen = 1;
         end else begin
            m_rot = (m_rot + 1) % 3;
         end
      end
   end

   task automatic chk(input string rq, input string what, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)", rq, what, act, exp, cyc);
      end
   endtask

   task automatic compare_all();
      string rq;
      if (!ext_ctl_n)                      rq = "R5";
      else if (m_req() == 3)               rq = "R6";
      else if (m_single != 0)              rq = "R4";
      else if (!line_start_n)              rq = "R3";
      else if (cfg_single_en != 1'b0)      rq = "R7";
      else                                 rq = "R2";
      chk(rq, "chan_sel", int'(chan_sel), m_eff());
      rq = (m_seen != 0) ? "R8" : "R9";
      chk(rq, "res_valid", int'(res_valid), m_pv[LAT]);
      chk(rq, "res_tag", int'(res_tag), m_pt[LAT]);
      chk(rq, "res_data", int'(res_data), m_pv[LAT] != 0 ? int'(conv_data) : 0);
      chk("R6", "err_rsvd", int'(err_rsvd), m_err);
   endtask

   task automatic run(input int n);
      for (int k = 0; k < n; k++) begin
         @(negedge clk);
         cyc++;
         conv_data = DW'((cyc * 149 + 7) & 12'hFFF);
         #1;
         compare_all();
      end
   endtask

   task automatic line_pulse(input int n);
      line_start_n = 1'b0;
      run(n);
      line_start_n = 1'b1;
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      #1;
      chk("R1", "reset chan_sel", int'(chan_sel), 0);
      chk("R1", "reset res_valid", int'(res_valid), 0);
      chk("R1", "reset res_tag", int'(res_tag), 0);
      chk("R1", "reset res_data", int'(res_data), 0);
      chk("R1", "reset err_rsvd", int'(err_rsvd), 0);
      rst_n = 1'b1;
   endtask

   initial begin
      do_reset();
      run(6);                          // R9: nothing valid before a line start
      line_pulse(2);                   // R3
      run(20);                         // R2 rotation and R8 tags
      cfg_single_en = 1'b1; cfg_color = 2'b01;
      run(9);                          // R7: mid-line change ignored
      line_pulse(1);
      run(12);                         // R4: fixed green
      cfg_color = 2'b10;
      line_pulse(1);
      run(10);                         // R4: fixed blue
      cfg_single_en = 1'b0; cfg_color = 2'b00;
      line_pulse(3);
      run(5);
      ext_ctl_n = 1'b0; ext_sel = 2'b01; run(3);   // R5
      ext_sel = 2'b10; run(3);
      ext_sel = 2'b00; run(2);
      ext_ctl_n = 1'b1; run(6);
      line_pulse(1);                   // R3 restart mid-rotation
      run(7);
      ext_ctl_n = 1'b0; ext_sel = 2'b11; run(2);   // R6 via pins
      ext_ctl_n = 1'b1; ext_sel = 2'b00; run(4);
      do_reset();
      cfg_single_en = 1'b1; cfg_color = 2'b11;
      line_pulse(1);
      run(8);                          // R6 via register
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      #(5.0 * 100000);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule